// File: doc/BRIEF.md
# Mode-Banked CPU Register File

This block is the register file a programmer sees on a 16-bit processor. It holds two accumulators (called A and B), two index registers (X, Y), a program counter, a frame pointer, a user stack pointer, a supervisor stack pointer and a flag word. The flag word carries the processor mode and the single ALU condition flag, the carry. The accumulator pair also reads and writes as one 32-bit value, D, with A as the high half. The low byte of A also reads and writes as the byte register C.

Two combinational read ports and one clocked write port address registers through a 4-bit select code. The generic stack-pointer code resolves to the supervisor copy in supervisor mode and to the user copy in user mode. The flag word and the two explicit stack-pointer codes are privileged. A user-mode attempt to write them is dropped and raises `privFault`. An interrupt-entry strobe forces supervisor mode. A separate strobe lets the ALU update the carry in any mode.

Top module: `regfile_top`

## Requirements
- R1: While `rstN` is low and after release, every register reads 0, `carryOut` is 0 and `superMode` is 1 (supervisor).
- R2: Codes A=0, B=1, X=3, Y=4, PC=6 and FP=7 name 16-bit registers. A write stores `wrData[15:0]`. A read returns the value zero-extended to 32 bits.
- R3: Code D=9 reads `{A,B}`. A write to D stores `wrData[31:16]` into A and `wrData[15:0]` into B.
- R4: Code C=2 reads `A[7:0]` zero-extended. A write to C replaces only `A[7:0]` with `wrData[7:0]` and leaves `A[15:8]` unchanged.
- R5: Code SP=5 reads and writes the supervisor stack pointer when `superMode` is 1, and the user stack pointer when it is 0.
- R6: Codes USP=10 and SSP=11 access the user and supervisor stack pointers directly, in supervisor mode only. In user mode they read 0, and a write is dropped with `privFault` high.
- R7: Code FLAGS=8 reads the flag word zero-extended: bit 0 is the carry, bit 1 is the mode (1 = supervisor), and bits 15:2 are plain storage. A supervisor write takes effect at the next clock edge.
- R8: In user mode a FLAGS write leaves the flag word unchanged. `privFault` is high in the same cycle, combinationally from `wrEn`, `wrSel` and the mode.
- R9: `intEnter` sets the mode to supervisor at the next edge. This overrides a FLAGS write in the same cycle.
- R10: `carryWe` loads `carryIn` into the carry at the next edge in any mode. A permitted FLAGS write in the same cycle takes precedence for the carry bit.
- R11: The two read ports decode their selects independently and combinationally. Codes 12 to 15 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdSelA | input | 4 | Read port A register select |
| rdDataA | output | 32 | Read port A data |
| rdSelB | input | 4 | Read port B register select |
| rdDataB | output | 32 | Read port B data |
| wrEn | input | 1 | Write enable |
| wrSel | input | 4 | Write register select |
| wrData | input | 32 | Write data |
| carryWe | input | 1 | ALU carry update strobe |
| carryIn | input | 1 | New carry value from the ALU |
| intEnter | input | 1 | Interrupt entry, forces supervisor mode |
| superMode | output | 1 | Current mode, 1 = supervisor |
| carryOut | output | 1 | Current carry flag |
| privFault | output | 1 | Privileged write attempted in user mode |

## Verification
The assertions check the following on every cycle:
- The D and C aliases agree with A when the two read ports look at them together.
- A blocked privileged write never coincides with supervisor mode.
- The mode stays user after a blocked write unless an interrupt intervenes.
- Interrupt entry always yields supervisor mode.
- A lone carry strobe lands in `carryOut`.

Only the bench scenarios can show the following:
- A byte write preserves the upper half of A.
- The generic stack-pointer code switches banks as the mode changes.
- A dropped write really left the stack pointer or flag word untouched.
- The priority between same-cycle flag writes, carry strobes and interrupts.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int WORD_W  = 16;
  localparam int DWORD_W = 2 * WORD_W;
  localparam int BYTE_W  = 8;
  localparam int SEL_W   = 4;
  localparam int CARRY_BIT = 0;
  localparam int MODE_BIT  = 1;

  typedef enum logic [SEL_W-1:0] {
    SEL_A     = 4'd0,
    SEL_B     = 4'd1,
    SEL_C     = 4'd2,
    SEL_X     = 4'd3,
    SEL_Y     = 4'd4,
    SEL_SP    = 4'd5,
    SEL_PC    = 4'd6,
    SEL_FP    = 4'd7,
    SEL_FLAGS = 4'd8,
    SEL_D     = 4'd9,
    SEL_USP   = 4'd10,
    SEL_SSP   = 4'd11
  } regSel_e;

  // write strobes from control to datapath
  typedef struct packed {
    logic wrAHi;
    logic wrALo;
    logic wrB;
    logic wrDouble;
    logic wrX;
    logic wrY;
    logic wrUsp;
    logic wrSsp;
    logic wrPc;
    logic wrFp;
    logic wrFlags;
    logic wrCarry;
    logic forceSuper;
  } ctrlStrobe_t;
endpackage

// File: rtl/regfile_ctrl.sv
module regfile_ctrl
  import regfile_pkg::*;
(
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic             superMode,
  input  logic             carryWe,
  input  logic             intEnter,
  output ctrlStrobe_t      strobe,
  output logic             privFault
);
  always_comb begin
    strobe     = '0;
    privFault  = 1'b0;
    strobe.wrCarry    = carryWe;
    strobe.forceSuper = intEnter;
    if (wrEn) begin
      case (wrSel)
        SEL_A: begin
          strobe.wrAHi = 1'b1;
          strobe.wrALo = 1'b1;
        end
        SEL_B:  strobe.wrB = 1'b1;
        SEL_C:  strobe.wrALo = 1'b1;
        SEL_D: begin
          strobe.wrAHi    = 1'b1;
          strobe.wrALo    = 1'b1;
          strobe.wrB      = 1'b1;
          strobe.wrDouble = 1'b1;
        end
        SEL_X:  strobe.wrX  = 1'b1;
        SEL_Y:  strobe.wrY  = 1'b1;
        SEL_PC: strobe.wrPc = 1'b1;
        SEL_FP: strobe.wrFp = 1'b1;
        SEL_SP: begin
          if (superMode) strobe.wrSsp = 1'b1;
          else           strobe.wrUsp = 1'b1;
        end
        SEL_USP: begin
          if (superMode) strobe.wrUsp = 1'b1;
          else           privFault    = 1'b1;
        end
        SEL_SSP: begin
          if (superMode) strobe.wrSsp = 1'b1;
          else           privFault    = 1'b1;
        end
        SEL_FLAGS: begin
          if (superMode) strobe.wrFlags = 1'b1;
          else           privFault      = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/regfile_dp.sv
module regfile_dp
  import regfile_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [DWORD_W-1:0] wrData,
  input  logic               carryIn,
  input  logic [SEL_W-1:0]   rdSelA,
  input  logic [SEL_W-1:0]   rdSelB,
  output logic [DWORD_W-1:0] rdDataA,
  output logic [DWORD_W-1:0] rdDataB,
  output logic               superMode,
  output logic               carryOut
);
  localparam int NUM_RD = 2;

  logic [WORD_W-1:0] regA, regB, regX, regY, regUsp, regSsp, regPc, regFp, regFlags;
  logic [WORD_W-1:0] aSrc;

  assign aSrc = strobe.wrDouble ? wrData[DWORD_W-1:WORD_W] : wrData[WORD_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regA <= '0; regB <= '0; regX <= '0; regY <= '0;
      regUsp <= '0; regSsp <= '0; regPc <= '0; regFp <= '0;
      regFlags <= WORD_W'(1) << MODE_BIT;
    end else begin
      if (strobe.wrAHi) regA[WORD_W-1:BYTE_W] <= aSrc[WORD_W-1:BYTE_W];
      if (strobe.wrALo) regA[BYTE_W-1:0]      <= aSrc[BYTE_W-1:0];
      if (strobe.wrB)   regB   <= wrData[WORD_W-1:0];
      if (strobe.wrX)   regX   <= wrData[WORD_W-1:0];
      if (strobe.wrY)   regY   <= wrData[WORD_W-1:0];
      if (strobe.wrUsp) regUsp <= wrData[WORD_W-1:0];
      if (strobe.wrSsp) regSsp <= wrData[WORD_W-1:0];
      if (strobe.wrPc)  regPc  <= wrData[WORD_W-1:0];
      if (strobe.wrFp)  regFp  <= wrData[WORD_W-1:0];
      if (strobe.wrFlags)
        regFlags[WORD_W-1:MODE_BIT+1] <= wrData[WORD_W-1:MODE_BIT+1];
      if (strobe.wrFlags)      regFlags[CARRY_BIT] <= wrData[CARRY_BIT];
      else if (strobe.wrCarry) regFlags[CARRY_BIT] <= carryIn;
      if (strobe.forceSuper)   regFlags[MODE_BIT] <= 1'b1;
      else if (strobe.wrFlags) regFlags[MODE_BIT] <= wrData[MODE_BIT];
    end
  end

  assign superMode = regFlags[MODE_BIT];
  assign carryOut  = regFlags[CARRY_BIT];

  logic [SEL_W-1:0]   rdSel  [NUM_RD];
  logic [DWORD_W-1:0] rdData [NUM_RD];
  assign rdSel[0] = rdSelA;
  assign rdSel[1] = rdSelB;
  assign rdDataA  = rdData[0];
  assign rdDataB  = rdData[1];

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rdPort
    always_comb begin
      rdData[p] = '0;
      case (rdSel[p])
        SEL_A:     rdData[p] = DWORD_W'(regA);
        SEL_B:     rdData[p] = DWORD_W'(regB);
        SEL_C:     rdData[p] = DWORD_W'(regA[BYTE_W-1:0]);
        SEL_D:     rdData[p] = {regA, regB};
        SEL_X:     rdData[p] = DWORD_W'(regX);
        SEL_Y:     rdData[p] = DWORD_W'(regY);
        SEL_PC:    rdData[p] = DWORD_W'(regPc);
        SEL_FP:    rdData[p] = DWORD_W'(regFp);
        SEL_SP:    rdData[p] = DWORD_W'(superMode ? regSsp : regUsp);
        SEL_USP:   rdData[p] = superMode ? DWORD_W'(regUsp) : '0;
        SEL_SSP:   rdData[p] = superMode ? DWORD_W'(regSsp) : '0;
        SEL_FLAGS: rdData[p] = DWORD_W'(regFlags);
        default:   rdData[p] = '0;
      endcase
    end
  end
endmodule

// File: rtl/regfile_top.sv
module regfile_top
  import regfile_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [SEL_W-1:0]   rdSelA,
  output logic [DWORD_W-1:0] rdDataA,
  input  logic [SEL_W-1:0]   rdSelB,
  output logic [DWORD_W-1:0] rdDataB,
  input  logic               wrEn,
  input  logic [SEL_W-1:0]   wrSel,
  input  logic [DWORD_W-1:0] wrData,
  input  logic               carryWe,
  input  logic               carryIn,
  input  logic               intEnter,
  output logic               superMode,
  output logic               carryOut,
  output logic               privFault
);
  ctrlStrobe_t strobe;

  regfile_ctrl u_ctrl (
    .wrEn(wrEn), .wrSel(wrSel), .superMode(superMode),
    .carryWe(carryWe), .intEnter(intEnter),
    .strobe(strobe), .privFault(privFault)
  );

  regfile_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .carryIn(carryIn), .rdSelA(rdSelA), .rdSelB(rdSelB),
    .rdDataA(rdDataA), .rdDataB(rdDataB),
    .superMode(superMode), .carryOut(carryOut)
  );
endmodule

// File: rtl/regfile_chk.sv
module regfile_chk
  import regfile_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [SEL_W-1:0]   rdSelA,
  input logic [DWORD_W-1:0] rdDataA,
  input logic [SEL_W-1:0]   rdSelB,
  input logic [DWORD_W-1:0] rdDataB,
  input logic               wrEn,
  input logic [SEL_W-1:0]   wrSel,
  input logic               carryWe,
  input logic               carryIn,
  input logic               intEnter,
  input logic               superMode,
  input logic               carryOut,
  input logic               privFault
);
  assert_d_alias_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdSelA == SEL_D && rdSelB == SEL_A) |-> rdDataA[DWORD_W-1:WORD_W] == rdDataB[WORD_W-1:0]);

  assert_c_alias_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdSelA == SEL_C && rdSelB == SEL_A) |->
      (rdDataA[BYTE_W-1:0] == rdDataB[BYTE_W-1:0] && rdDataA[DWORD_W-1:BYTE_W] == '0));

  assert_fault_user_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    privFault |-> (!superMode && wrEn));

  assert_blocked_keeps_user_R8: assert property (@(posedge clk) disable iff (!rstN)
    (privFault && !intEnter) |=> !superMode);

  assert_int_super_R9: assert property (@(posedge clk) disable iff (!rstN)
    intEnter |=> superMode);

  assert_carry_update_R10: assert property (@(posedge clk) disable iff (!rstN)
    (carryWe && !(wrEn && wrSel == SEL_FLAGS && superMode)) |=> carryOut == $past(carryIn));
endmodule

bind regfile_top regfile_chk u_chk (
  .clk(clk), .rstN(rstN), .rdSelA(rdSelA), .rdDataA(rdDataA),
  .rdSelB(rdSelB), .rdDataB(rdDataB), .wrEn(wrEn), .wrSel(wrSel),
  .carryWe(carryWe), .carryIn(carryIn), .intEnter(intEnter),
  .superMode(superMode), .carryOut(carryOut), .privFault(privFault)
);

// File: tb/regfile_top_tb.sv
module regfile_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  rdSelA = '0, rdSelB = '0, wrSel = '0;
  logic [31:0] rdDataA, rdDataB, wrData = '0;
  logic        wrEn = 1'b0, carryWe = 1'b0, carryIn = 1'b0, intEnter = 1'b0;
  logic        superMode, carryOut, privFault;
  int          nChecks = 0, nFails = 0;

  always #5 clk = ~clk;

  regfile_top u_dut (
    .clk(clk), .rstN(rstN), .rdSelA(rdSelA), .rdDataA(rdDataA),
    .rdSelB(rdSelB), .rdDataB(rdDataB), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .carryWe(carryWe), .carryIn(carryIn),
    .intEnter(intEnter), .superMode(superMode), .carryOut(carryOut),
    .privFault(privFault)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [3:0] sel, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readA(input string tag, input logic [3:0] sel, input logic [31:0] exp);
    rdSelA = sel;
    #1;
    check(tag, rdDataA, exp);
  endtask

  // write select, write data, read select, expected read (supervisor mode)
  localparam int NV = 12;
  localparam logic [3:0]  V_WSEL [NV] = '{4'd0, 4'd1, 4'd2, 4'd9, 4'd3, 4'd4,
                                          4'd6, 4'd7, 4'd5, 4'd10, 4'd2, 4'd12};
  localparam logic [31:0] V_WDAT [NV] = '{32'h0000_1234, 32'h0000_BEEF, 32'hFFFF_FFA5,
                                          32'hCAFE_0001, 32'hFFFF_5555, 32'h0000_AAAA,
                                          32'h0000_0100, 32'h0000_0200, 32'h0000_7F00,
                                          32'h0000_3000, 32'h0000_0077, 32'h0000_1111};
  localparam logic [3:0]  V_RSEL [NV] = '{4'd0, 4'd9, 4'd0, 4'd1, 4'd3, 4'd4,
                                          4'd6, 4'd7, 4'd11, 4'd5, 4'd2, 4'd12};
  localparam logic [31:0] V_EXP  [NV] = '{32'h0000_1234,  // R2 A
                                          32'h1234_BEEF,  // R3 D read
                                          32'h0000_12A5,  // R4 C write keeps A hi
                                          32'h0000_0001,  // R3 D write low to B
                                          32'h0000_5555,  // R2 X
                                          32'h0000_AAAA,  // R2 Y
                                          32'h0000_0100,  // R2 PC
                                          32'h0000_0200,  // R2 FP
                                          32'h0000_7F00,  // R5 SP -> SSP
                                          32'h0000_7F00,  // R6 USP write, SP still SSP
                                          32'h0000_0077,  // R4 C read
                                          32'h0000_0000}; // R11 unused code

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    readA("R1 A", 4'd0, 32'h0);
    readA("R1 SP", 4'd5, 32'h0);
    check("R1 mode", {31'b0, superMode}, 32'd1);
    check("R1 carry", {31'b0, carryOut}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    readA("R1 flags", 4'd8, 32'h0000_0002);

    for (int i = 0; i < NV; i++) begin
      doWrite(V_WSEL[i], V_WDAT[i]);
      readA($sformatf("vector %0d", i), V_RSEL[i], V_EXP[i]);
    end
    // R3 D read after C write: A=CA77, B=0001
    readA("R3 D", 4'd9, 32'hCA77_0001);
    // R11 two ports independent
    rdSelB = 4'd3; #1;
    check("R11 port B", rdDataB, 32'h0000_5555);

    // R7 supervisor flag write sets carry
    doWrite(4'd8, 32'h0000_8003);
    check("R7 carry", {31'b0, carryOut}, 32'd1);
    readA("R7 flags", 4'd8, 32'h0000_8003);
    // R10 carry strobe
    @(negedge clk); carryWe = 1'b1; carryIn = 1'b0;
    @(negedge clk); carryWe = 1'b0;
    check("R10 carry load", {31'b0, carryOut}, 32'd0);
    // R10 flag write wins over carry strobe
    @(negedge clk); carryWe = 1'b1; carryIn = 1'b0;
    wrEn = 1'b1; wrSel = 4'd8; wrData = 32'h0000_0003;
    @(negedge clk); carryWe = 1'b0; wrEn = 1'b0;
    check("R10 flag priority", {31'b0, carryOut}, 32'd1);

    // R7 drop to user mode
    doWrite(4'd8, 32'h0000_0000);
    check("R7 user mode", {31'b0, superMode}, 32'd0);
    // R5 SP now resolves to USP
    readA("R5 SP user", 4'd5, 32'h0000_3000);
    doWrite(4'd5, 32'h0000_3100);
    readA("R5 SP user write", 4'd5, 32'h0000_3100);
    // R6 privileged stack codes in user mode
    readA("R6 USP read user", 4'd10, 32'h0);
    @(negedge clk); wrEn = 1'b1; wrSel = 4'd11; wrData = 32'h0000_DEAD; #1;
    check("R6 fault", {31'b0, privFault}, 32'd1);
    @(negedge clk); wrEn = 1'b0;
    // R8 user flag write blocked
    @(negedge clk); wrEn = 1'b1; wrSel = 4'd8; wrData = 32'h0000_0003; #1;
    check("R8 fault", {31'b0, privFault}, 32'd1);
    @(negedge clk); wrEn = 1'b0; #1;
    check("R8 mode kept", {31'b0, superMode}, 32'd0);
    check("R8 no fault idle", {31'b0, privFault}, 32'd0);
    readA("R8 flags kept", 4'd8, 32'h0);

    // R9 interrupt entry
    @(negedge clk); intEnter = 1'b1;
    @(negedge clk); intEnter = 1'b0;
    check("R9 super", {31'b0, superMode}, 32'd1);
    readA("R6 SSP untouched", 4'd5, 32'h0000_7F00);
    readA("R6 USP super", 4'd10, 32'h0000_3100);
    // R9 interrupt overrides same-cycle flag write
    @(negedge clk); intEnter = 1'b1;
    wrEn = 1'b1; wrSel = 4'd8; wrData = 32'h0000_0000;
    @(negedge clk); intEnter = 1'b0; wrEn = 1'b0;
    check("R9 override", {31'b0, superMode}, 32'd1);

    // R11 write to unused code leaves registers alone
    doWrite(4'd15, 32'hFFFF_FFFF);
    readA("R11 A intact", 4'd9, 32'hCA77_0001);

    // R1 reset mid-run
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    readA("R1 A cleared", 4'd9, 32'h0);
    check("R1 super", {31'b0, superMode}, 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule